// File: doc/BRIEF.md
# Execution Priority and Preemption Unit

This block works out the priority level at which a processor core is currently running. It then rules on whether one candidate exception, handed over by an external selector, may interrupt that context. The running level comes from the set of active exceptions. Each active exception has a configurable 8-bit priority, and the hard-fault and NMI levels are fixed. Three software controls can raise that level: an interrupt-mask bit, a fault-mask bit and an 8-bit base threshold. Priorities are signed levels where a smaller number is more urgent. The idle level is 256, hard fault is -1, NMI is -2 and reset is -3.

Only the group part of a configurable priority counts when levels are compared. A 3-bit split selector decides how many low-order bits are sub-priority, and those bits are ignored here. Unimplemented low-order bits always read as zero. The candidate arrives on a valid/ready channel. The ruling is a registered preempt request or a registered escalate-to-hard-fault request. Whichever is raised holds until the core acknowledges it. While a ruling is outstanding the channel applies back-pressure, and the selector must keep its candidate stable until it sees ready.

Top module: `exec_prio_unit`

## Requirements
- R1: With no exception active, both mask bits clear and an ineffective threshold, exec_prio is 256.
- R2: With exceptions active, exec_prio is the smallest level among them. Each active configurable entry contributes its group value, hard_flt_act contributes -1 and nmi_act contributes -2.
- R3: A group value is the priority with its low (split_sel+1) bits cleared and with the bits below the top IMPL_BITS (default 4) cleared. split_sel of 7 makes every group value 0.
- R4: With mask_irq set, exec_prio is at most 0.
- R5: With mask_flt set, exec_prio is at most -1.
- R6: A base_thr whose group value is nonzero lowers exec_prio to that group value when the group value is smaller. A base_thr whose group value is zero has no effect.
- R7: An interrupt candidate (cand_kind 0) raises preempt_req only when its group value is strictly below exec_prio. An equal or larger group value raises nothing.
- R8: A fault candidate (cand_kind 1) raises preempt_req when its handler is enabled and its group value is strictly below exec_prio. If instead its handler is disabled or its group value is not below exec_prio, it raises escalate, but only when exec_prio is above -1. Otherwise it raises neither.
- R9: An NMI candidate (cand_kind 2) preempts only when exec_prio is above -2. A reset candidate (cand_kind 3) always preempts.
- R10: A candidate is accepted on a clock edge where cand_valid and cand_ready are both high. cand_ready is high when no ruling is outstanding or when ack is high. The ruling appears in the cycle after acceptance and holds until a clock edge with ack. preempt_req and escalate are never high together. If ack and a new acceptance share an edge, the new ruling replaces the old one.
- R11: After reset, preempt_req and escalate are low and cand_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| act_vec | input | N | Active flags of configurable exceptions |
| act_prio | input | N*8 | Priorities of configurable exceptions, entry i at bits [8i+7:8i] |
| nmi_act | input | 1 | NMI handler active (level -2) |
| hard_flt_act | input | 1 | Hard-fault handler active (level -1) |
| split_sel | input | 3 | Sub-priority split: low split_sel+1 bits are sub-priority |
| mask_irq | input | 1 | Interrupt mask, ceiling 0 |
| mask_flt | input | 1 | Fault mask, ceiling -1 |
| base_thr | input | 8 | Base priority threshold, 0 = off |
| cand_valid | input | 1 | Candidate offered |
| cand_ready | output | 1 | Candidate can be taken |
| cand_kind | input | 2 | 0 interrupt, 1 fault, 2 NMI, 3 reset |
| cand_prio | input | 8 | Candidate priority (kinds 0 and 1) |
| cand_hdl_en | input | 1 | Fault handler enabled |
| ack | input | 1 | Core has consumed the ruling |
| exec_prio | output | 10 | Current execution level, two's complement |
| preempt_req | output | 1 | Candidate may be taken now |
| escalate | output | 1 | Take a hard fault instead of the candidate |

## Verification
Two things can happen on the same clock edge: an acknowledge that clears an outstanding ruling, and the acceptance of a new candidate. The bench holds a preempt ruling unacknowledged while it offers a fault with its handler disabled. It first checks that the fault is held off and the old ruling stays in place. It then raises ack with the fault still offered. After that one edge it expects escalate high and preempt_req low, and a later lone ack must leave both low. In the same way, a mask written in the cycle a candidate is offered must govern that ruling, so changes to the mask bits and candidate offers are interleaved.

// File: rtl/epu_pkg.sv
package epu_pkg;
  localparam int PW = 8;
  localparam int XW = 10;

  typedef logic signed [XW-1:0] xlvl_t;

  typedef enum logic [1:0] {
    K_IRQ   = 2'd0,
    K_FAULT = 2'd1,
    K_NMI   = 2'd2,
    K_RESET = 2'd3
  } cand_kind_e;

  localparam xlvl_t LVL_IDLE = 10'sd256;
  localparam xlvl_t LVL_ZERO = 10'sd0;
  localparam xlvl_t LVL_HF   = -10'sd1;
  localparam xlvl_t LVL_NMI  = -10'sd2;

  function automatic xlvl_t widen(input logic [PW-1:0] g);
    return $signed({2'b00, g});
  endfunction
endpackage

// File: rtl/epu_grouper.sv
module epu_grouper #(
  parameter int PW        = 8,
  parameter int IMPL_BITS = 4
) (
  input  logic [PW-1:0] prio,
  input  logic [2:0]    split_sel,
  output logic [PW-1:0] grp
);
  localparam logic [PW-1:0] IMPL_MASK = ~({PW{1'b1}} >> IMPL_BITS);

  logic [3:0]    sub_bits;
  logic [PW:0]   wide_mask;
  logic [PW-1:0] grp_mask;

  always_comb begin
    sub_bits  = {1'b0, split_sel} + 4'd1;
    wide_mask = {(PW+1){1'b1}} << sub_bits;
    grp_mask  = wide_mask[PW-1:0];
    grp       = prio & IMPL_MASK & grp_mask;
  end
endmodule

// File: rtl/epu_act_min.sv
module epu_act_min
  import epu_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [N-1:0]    act_vec,
  input  logic [N*PW-1:0] act_grp,
  input  logic            nmi_act,
  input  logic            hard_flt_act,
  output xlvl_t           act_lvl
);
  xlvl_t entry_lvl [N];

  for (genvar i = 0; i < N; i++) begin : g_entry
    assign entry_lvl[i] = act_vec[i] ? widen(act_grp[i*PW +: PW]) : LVL_IDLE;
  end

  always_comb begin
    act_lvl = LVL_IDLE;
    for (int i = 0; i < N; i++) begin
      if (entry_lvl[i] < act_lvl) act_lvl = entry_lvl[i];
    end
    if (hard_flt_act && LVL_HF < act_lvl) act_lvl = LVL_HF;
    if (nmi_act && LVL_NMI < act_lvl)     act_lvl = LVL_NMI;
  end
endmodule

// File: rtl/epu_ceiling.sv
module epu_ceiling
  import epu_pkg::*;
(
  input  xlvl_t         act_lvl,
  input  logic          mask_irq,
  input  logic          mask_flt,
  input  logic [PW-1:0] thr_grp,
  output xlvl_t         exec_lvl
);
  xlvl_t thr_lvl;

  always_comb begin
    thr_lvl  = (thr_grp != '0) ? widen(thr_grp) : LVL_IDLE;
    exec_lvl = act_lvl;
    if (thr_lvl < exec_lvl)               exec_lvl = thr_lvl;
    if (mask_irq && LVL_ZERO < exec_lvl)  exec_lvl = LVL_ZERO;
    if (mask_flt && LVL_HF < exec_lvl)    exec_lvl = LVL_HF;
  end
endmodule

// File: rtl/epu_decide.sv
module epu_decide
  import epu_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  xlvl_t         exec_lvl,
  input  logic          cand_valid,
  output logic          cand_ready,
  input  logic [1:0]    cand_kind,
  input  logic [PW-1:0] cand_grp,
  input  logic          cand_hdl_en,
  input  logic          ack,
  output logic          preempt_req,
  output logic          escalate
);
  logic       busy;
  logic       take;
  logic       want_pre;
  logic       want_esc;
  logic       beats;
  cand_kind_e kind;

  assign busy       = preempt_req | escalate;
  assign cand_ready = ~busy | ack;
  assign take       = cand_valid & cand_ready;

  always_comb begin
    kind     = cand_kind_e'(cand_kind);
    beats    = widen(cand_grp) < exec_lvl;
    want_pre = 1'b0;
    want_esc = 1'b0;
    unique case (kind)
      K_IRQ:   want_pre = beats;
      K_FAULT: begin
        if (cand_hdl_en && beats)   want_pre = 1'b1;
        else if (LVL_HF < exec_lvl) want_esc = 1'b1;
      end
      K_NMI:   want_pre = LVL_NMI < exec_lvl;
      K_RESET: want_pre = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      preempt_req <= 1'b0;
      escalate    <= 1'b0;
    end else if (take) begin
      preempt_req <= want_pre;
      escalate    <= want_esc;
    end else if (ack) begin
      preempt_req <= 1'b0;
      escalate    <= 1'b0;
    end
  end
endmodule

// File: rtl/exec_prio_unit.sv
module exec_prio_unit
  import epu_pkg::*;
#(
  parameter int N         = 8,
  parameter int IMPL_BITS = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    act_vec,
  input  logic [N*8-1:0]  act_prio,
  input  logic            nmi_act,
  input  logic            hard_flt_act,
  input  logic [2:0]      split_sel,
  input  logic            mask_irq,
  input  logic            mask_flt,
  input  logic [7:0]      base_thr,
  input  logic            cand_valid,
  output logic            cand_ready,
  input  logic [1:0]      cand_kind,
  input  logic [7:0]      cand_prio,
  input  logic            cand_hdl_en,
  input  logic            ack,
  output logic [9:0]      exec_prio,
  output logic            preempt_req,
  output logic            escalate
);
  logic [N*PW-1:0] act_grp;
  logic [PW-1:0]   thr_grp;
  logic [PW-1:0]   cand_grp;
  xlvl_t           act_lvl;
  xlvl_t           exec_lvl;

  for (genvar i = 0; i < N; i++) begin : g_grp
    epu_grouper #(.PW(PW), .IMPL_BITS(IMPL_BITS)) u_grp (
      .prio(act_prio[i*PW +: PW]), .split_sel(split_sel), .grp(act_grp[i*PW +: PW])
    );
  end

  epu_grouper #(.PW(PW), .IMPL_BITS(IMPL_BITS)) u_thr_grp (
    .prio(base_thr), .split_sel(split_sel), .grp(thr_grp)
  );

  epu_grouper #(.PW(PW), .IMPL_BITS(IMPL_BITS)) u_cand_grp (
    .prio(cand_prio), .split_sel(split_sel), .grp(cand_grp)
  );

  epu_act_min #(.N(N)) u_act_min (
    .act_vec(act_vec), .act_grp(act_grp), .nmi_act(nmi_act),
    .hard_flt_act(hard_flt_act), .act_lvl(act_lvl)
  );

  epu_ceiling u_ceiling (
    .act_lvl(act_lvl), .mask_irq(mask_irq), .mask_flt(mask_flt),
    .thr_grp(thr_grp), .exec_lvl(exec_lvl)
  );

  epu_decide u_decide (
    .clk(clk), .rst_n(rst_n), .exec_lvl(exec_lvl),
    .cand_valid(cand_valid), .cand_ready(cand_ready), .cand_kind(cand_kind),
    .cand_grp(cand_grp), .cand_hdl_en(cand_hdl_en), .ack(ack),
    .preempt_req(preempt_req), .escalate(escalate)
  );

  assign exec_prio = exec_lvl;
endmodule

// File: rtl/exec_prio_unit_chk.sv
module exec_prio_unit_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] act_vec,
  input logic         nmi_act,
  input logic         hard_flt_act,
  input logic         mask_irq,
  input logic         mask_flt,
  input logic [7:0]   base_thr,
  input logic         cand_valid,
  input logic         cand_ready,
  input logic [1:0]   cand_kind,
  input logic         ack,
  input logic [9:0]   exec_prio,
  input logic         preempt_req,
  input logic         escalate
);
  a_r1_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    (act_vec == '0 && !nmi_act && !hard_flt_act && !mask_irq && !mask_flt && base_thr == 8'd0)
      |-> exec_prio == 10'd256);

  a_r4_irq_mask_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
    mask_irq |-> $signed(exec_prio) <= 10'sd0);

  a_r5_flt_mask_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
    mask_flt |-> $signed(exec_prio) <= -10'sd1);

  a_r9_reset_always: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_valid && cand_ready && cand_kind == 2'd3) |=> preempt_req);

  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(preempt_req && escalate));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((preempt_req || escalate) && !ack) |=> ($stable(preempt_req) && $stable(escalate)));

  a_r10_backpressure: assert property (@(posedge clk) disable iff (!rst_n)
    ((preempt_req || escalate) && !ack) |-> !cand_ready);

  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (!(cand_valid && cand_ready) && (ack || !(preempt_req || escalate)))
      |=> (!preempt_req && !escalate));
endmodule

bind exec_prio_unit exec_prio_unit_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .act_vec(act_vec), .nmi_act(nmi_act),
  .hard_flt_act(hard_flt_act), .mask_irq(mask_irq), .mask_flt(mask_flt),
  .base_thr(base_thr), .cand_valid(cand_valid), .cand_ready(cand_ready),
  .cand_kind(cand_kind), .ack(ack), .exec_prio(exec_prio),
  .preempt_req(preempt_req), .escalate(escalate)
);

// File: tb/test_exec_prio_unit.sv
`timescale 1ns/1ps
module test_exec_prio_unit;
  localparam int N = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [N-1:0]   act_vec = '0;
  logic [N*8-1:0] act_prio = '0;
  logic           nmi_act = 1'b0;
  logic           hard_flt_act = 1'b0;
  logic [2:0]     split_sel = 3'd3;
  logic           mask_irq = 1'b0;
  logic           mask_flt = 1'b0;
  logic [7:0]     base_thr = 8'd0;
  logic           cand_valid = 1'b0;
  logic           cand_ready;
  logic [1:0]     cand_kind = 2'd0;
  logic [7:0]     cand_prio = 8'd0;
  logic           cand_hdl_en = 1'b0;
  logic           ack = 1'b0;
  logic [9:0]     exec_prio;
  logic           preempt_req;
  logic           escalate;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  exec_prio_unit #(.N(N)) i_exec_prio_unit (
    .clk(clk), .rst_n(rst_n), .act_vec(act_vec), .act_prio(act_prio),
    .nmi_act(nmi_act), .hard_flt_act(hard_flt_act), .split_sel(split_sel),
    .mask_irq(mask_irq), .mask_flt(mask_flt), .base_thr(base_thr),
    .cand_valid(cand_valid), .cand_ready(cand_ready), .cand_kind(cand_kind),
    .cand_prio(cand_prio), .cand_hdl_en(cand_hdl_en), .ack(ack),
    .exec_prio(exec_prio), .preempt_req(preempt_req), .escalate(escalate)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_lvl(input string req, input int exp);
    #1;
    chk(req, int'($signed(exec_prio)), exp);
  endtask

  task automatic clear_all();
    @(negedge clk);
    act_vec = '0; act_prio = '0; nmi_act = 0; hard_flt_act = 0;
    split_sel = 3'd3; mask_irq = 0; mask_flt = 0; base_thr = 8'd0;
  endtask

  task automatic set_act(input int idx, input logic [7:0] p);
    act_vec[idx] = 1'b1;
    act_prio[idx*8 +: 8] = p;
  endtask

  task automatic offer(input string req, input logic [1:0] k, input logic [7:0] p,
                       input logic en, input logic ep, input logic ee);
    @(negedge clk);
    cand_valid = 1; cand_kind = k; cand_prio = p; cand_hdl_en = en;
    @(negedge clk);
    cand_valid = 0;
    chk({req, " preempt"}, int'(preempt_req), int'(ep));
    chk({req, " escalate"}, int'(escalate), int'(ee));
    if (ep || ee) begin
      ack = 1;
      @(negedge clk);
      ack = 0;
      chk("R10 ack clears", int'(preempt_req | escalate), 0);
    end
  endtask

  task automatic t_reset();
    #1;
    chk("R11 preempt_req after reset", int'(preempt_req), 0);
    chk("R11 escalate after reset", int'(escalate), 0);
    chk("R11 cand_ready after reset", int'(cand_ready), 1);
    chk_lvl("R1 idle level", 256);
  endtask

  task automatic t_active();
    clear_all();
    set_act(2, 8'h60); set_act(5, 8'h40);
    chk_lvl("R2 min of active", 64);
    hard_flt_act = 1;
    chk_lvl("R2 hard fault active", -1);
    nmi_act = 1;
    chk_lvl("R2 nmi active", -2);
  endtask

  task automatic t_grouping();
    clear_all();
    set_act(0, 8'h4F);
    chk_lvl("R3 unimplemented bits zero", 64);
    split_sel = 3'd5; act_prio[7:0] = 8'h70;
    chk_lvl("R3 sub-priority bits dropped", 64);
    split_sel = 3'd7; act_prio[7:0] = 8'h80;
    chk_lvl("R3 split 7 all group zero", 0);
  endtask

  task automatic t_masks();
    clear_all();
    set_act(1, 8'h40);
    mask_irq = 1;
    chk_lvl("R4 interrupt mask", 0);
    mask_flt = 1;
    chk_lvl("R5 fault mask", -1);
    clear_all();
    base_thr = 8'h30;
    chk_lvl("R6 threshold idle", 48);
    set_act(3, 8'h20);
    chk_lvl("R6 threshold above active", 32);
    clear_all();
    base_thr = 8'h0F;
    chk_lvl("R6 threshold group zero ignored", 256);
    split_sel = 3'd7; base_thr = 8'h80;
    chk_lvl("R6 threshold zero group at split 7", 256);
  endtask

  task automatic t_preempt();
    clear_all();
    set_act(4, 8'h40);
    offer("R7 higher irq", 2'd0, 8'h30, 1'b0, 1'b1, 1'b0);
    offer("R7 equal irq", 2'd0, 8'h40, 1'b0, 1'b0, 1'b0);
    offer("R7 equal group diff sub", 2'd0, 8'h4C, 1'b0, 1'b0, 1'b0);
    offer("R7 lower irq", 2'd0, 8'h50, 1'b0, 1'b0, 1'b0);
    @(negedge clk); mask_irq = 1;
    offer("R4 irq blocked by mask", 2'd0, 8'h00, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_fault();
    clear_all();
    set_act(4, 8'h40);
    offer("R8 enabled fault", 2'd1, 8'h20, 1'b1, 1'b1, 1'b0);
    offer("R8 disabled fault", 2'd1, 8'h20, 1'b0, 1'b0, 1'b1);
    offer("R8 low fault", 2'd1, 8'h60, 1'b1, 1'b0, 1'b1);
    @(negedge clk); hard_flt_act = 1;
    offer("R8 no escalate at -1", 2'd1, 8'h60, 1'b1, 1'b0, 1'b0);
    @(negedge clk); hard_flt_act = 0; mask_flt = 1;
    offer("R8 fault mask stops escalate", 2'd1, 8'h00, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_nmi_reset();
    clear_all();
    mask_flt = 1;
    offer("R9 nmi over fault mask", 2'd2, 8'h00, 1'b0, 1'b1, 1'b0);
    @(negedge clk); nmi_act = 1;
    offer("R9 nmi while nmi active", 2'd2, 8'h00, 1'b0, 1'b0, 1'b0);
    offer("R9 reset always", 2'd3, 8'h00, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_handshake();
    clear_all();
    @(negedge clk);
    cand_valid = 1; cand_kind = 2'd0; cand_prio = 8'h10; cand_hdl_en = 0;
    @(negedge clk);
    cand_kind = 2'd1; cand_prio = 8'h10; cand_hdl_en = 0;
    chk("R10 ruling after accept", int'(preempt_req), 1);
    chk("R10 ready low while busy", int'(cand_ready), 0);
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      chk("R10 hold without ack", int'(preempt_req), 1);
      chk("R10 held fault not taken", int'(escalate), 0);
    end
    mask_flt = 1;
    #1;
    chk("R10 busy blocks ready", int'(cand_ready), 0);
    @(negedge clk);
    mask_flt = 0;
    ack = 1;
    #1;
    chk("R10 ack opens ready", int'(cand_ready), 1);
    @(negedge clk);
    ack = 0; cand_valid = 0;
    chk("R10 ack and accept same edge preempt", int'(preempt_req), 0);
    chk("R10 ack and accept same edge escalate", int'(escalate), 1);
    ack = 1;
    @(negedge clk);
    ack = 0;
    chk("R10 lone ack clears", int'(preempt_req | escalate), 0);
    @(negedge clk);
    chk("R10 stays clear", int'(preempt_req | escalate), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_active();
    t_grouping();
    t_masks();
    t_preempt();
    t_fault();
    t_nmi_reset();
    t_handshake();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      done = 1;
      tests++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule